// File: doc/BRIEF.md
# Dual-Byte Baud Timer

This block is a configurable timer that produces the bit-rate shift strobe for a serial shifter. It is built from two 8-bit down-counters in cascade, both loaded from one 16-bit compare input. The low byte sets the baud divider. The high byte sets how many shift edges make up one word. Each time the low counter expires, the timer output level toggles and a one-cycle shift strobe is raised, so one full output period lasts (low byte + 1) * 2 clock cycles. The high counter counts these edges and raises a compare event after (high byte + 1) of them, so a high byte of 0x0F frames an 8-bit word.

Static configuration inputs control the rest of the timer. They choose what starts it: either a trigger that is held active, or a rising edge on a pin input. They choose what stops it: never, on every compare, or on a compare that finds the trigger inactive. They choose whether a trigger rising edge reloads the counters. They can also add a start bit period before the word and a stop bit period after it. The trigger comes either from an internal shifter status flag or from an external input, and its active level can be inverted. A sticky status flag records compare events and is cleared by a one-cycle clear pulse.

Top module: `baud_timer`

## Requirements
- R1: After reset, shift_pulse, tmr_out and tmr_stat are all 0.
- R2: When cfg_mode is 0 (timer off), the timer does not run, and the cycle after cfg_mode goes to 0 both shift_pulse and tmr_out are 0. cfg_mode 1 selects the dual-byte baud mode.
- R3: While the timer runs, shift_pulse is high for one cycle every L+1 cycles, where L is cfg_cmp[7:0]. The first strobe comes L+1 cycles after the enabling clock edge, and tmr_out toggles on every strobe.
- R4: In the run phase, a compare event occurs on the (H+1)-th strobe, where H is cfg_cmp[15:8]. With cfg_dis_sel 1 the timer stops at that compare, so a word with no framing has exactly H+1 strobes.
- R5: With cfg_start_en 1, two extra strobes (one bit period) come after enable and before the word counter begins.
- R6: With cfg_stop_sel 1, two extra strobes come after a compare that disables the timer. With cfg_stop_sel 2, two extra strobes come after every compare. With cfg_stop_sel 0, no extra strobes are added.
- R7: With cfg_ena_sel 1, a rising edge of pin_in while the timer is idle starts it, and tmr_out is 1 from the following cycle.
- R8: With cfg_ena_sel 0, the timer starts whenever the trigger is active while idle. The trigger is shf_flag when cfg_trig_src is 0 and trig_ext when it is 1. It is active high when cfg_trig_pol is 0 and active low when cfg_trig_pol is 1.
- R9: With cfg_dis_sel 2, a compare stops the timer only when the trigger is inactive. While the trigger stays active, the timer reloads and keeps running.
- R10: With cfg_rst_sel 1, a trigger rising edge while the timer runs reloads both counters. tmr_out is then forced to 1 if cfg_out_sel is 0, and it is left unchanged if cfg_out_sel is 1.
- R11: tmr_stat becomes 1 on the cycle after a compare event and stays set until a stat_clr pulse clears it.
- R12: While the timer is stopped, tmr_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_mode | input | 2 | 0 off, 1 dual-byte baud mode |
| cfg_cmp | input | 16 | [7:0] baud divider, [15:8] edges per word minus one |
| cfg_ena_sel | input | 1 | 0 run while trigger active, 1 start on pin rising edge |
| cfg_dis_sel | input | 2 | 0 never, 1 on compare, 2 on compare with trigger inactive |
| cfg_rst_sel | input | 1 | 1 reload counters on trigger rising edge |
| cfg_out_sel | input | 1 | 0 reload sets output to 1, 1 reload leaves output alone |
| cfg_start_en | input | 1 | Insert a start bit period after enable |
| cfg_stop_sel | input | 2 | 0 none, 1 stop bit before disable, 2 stop bit on every compare |
| cfg_trig_src | input | 1 | 0 internal shifter flag, 1 external trigger |
| cfg_trig_pol | input | 1 | 0 active high, 1 active low |
| shf_flag | input | 1 | Internal shifter status flag |
| trig_ext | input | 1 | External trigger input |
| pin_in | input | 1 | Pin input used for edge enable |
| stat_clr | input | 1 | One-cycle pulse that clears tmr_stat |
| shift_pulse | output | 1 | One-cycle shift strobe on each output edge |
| tmr_out | output | 1 | Timer output level |
| tmr_stat | output | 1 | Sticky compare status flag |

## Verification
The bench uses a zero baud divider, where a strobe appears every cycle. A design that reloads the low counter one cycle late would halve that rate, and one that skips reload would stall. Random divider and word sizes, combined with start and stop framing, test the strobe count, the spacing and the position of the last strobe. An off-by-one in the word counter, or missing framing, changes the count by one or two. A trigger rising edge is applied mid-word, when the output is low, under both output options. A design that ignores the reload ends the word early, and one that mishandles the output option shows the wrong level. Trigger-held runs in the compare-and-trigger stop mode must keep going past one word and then stop exactly on a word boundary. Stopping mid-word would leave a strobe count that is not a multiple of the word length.

// File: rtl/baud_timer.sv
module baud_timer #(
  parameter int CMP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_mode,
  input  logic [CMP_W-1:0] cfg_cmp,
  input  logic             cfg_ena_sel,
  input  logic [1:0]       cfg_dis_sel,
  input  logic             cfg_rst_sel,
  input  logic             cfg_out_sel,
  input  logic             cfg_start_en,
  input  logic [1:0]       cfg_stop_sel,
  input  logic             cfg_trig_src,
  input  logic             cfg_trig_pol,
  input  logic             shf_flag,
  input  logic             trig_ext,
  input  logic             pin_in,
  input  logic             stat_clr,
  output logic             shift_pulse,
  output logic             tmr_out,
  output logic             tmr_stat
);
  localparam int BW = CMP_W / 2;
  localparam logic [1:0] MODE_BAUD = 2'd1;
  localparam logic [BW-1:0] ONE = 1;

  typedef enum logic [1:0] {PH_START, PH_RUN, PH_STOP} phase_t;

  logic          en, sub, dis_pend, trig_q, pin_q;
  logic [BW-1:0] lo_cnt, hi_cnt;
  phase_t        phase;

  logic [BW-1:0] lo_ld, hi_ld;
  logic trig_act, trig_rise, pin_rise, mode_on;
  logic ena_evt, rst_evt, tick, cmp_evt, dis_cond, stop_now, frame_end, go_off;

  assign lo_ld     = cfg_cmp[BW-1:0];
  assign hi_ld     = cfg_cmp[CMP_W-1:BW];
  assign trig_act  = (cfg_trig_src ? trig_ext : shf_flag) ^ cfg_trig_pol;
  assign trig_rise = trig_act & ~trig_q;
  assign pin_rise  = pin_in & ~pin_q;
  assign mode_on   = (cfg_mode == MODE_BAUD);
  assign ena_evt   = mode_on & ~en & (cfg_ena_sel ? pin_rise : trig_act);
  assign rst_evt   = en & cfg_rst_sel & trig_rise;
  assign tick      = en & (lo_cnt == '0);
  assign cmp_evt   = tick & ~rst_evt & (phase == PH_RUN) & (hi_cnt == '0);
  assign dis_cond  = (cfg_dis_sel == 2'd1) | ((cfg_dis_sel == 2'd2) & ~trig_act);
  assign stop_now  = (cfg_stop_sel == 2'd2) | ((cfg_stop_sel == 2'd1) & dis_cond);
  assign frame_end = tick & ~rst_evt & sub & (phase != PH_RUN);
  assign go_off    = (cmp_evt & ~stop_now & dis_cond)
                   | (frame_end & (phase == PH_STOP) & dis_pend);

  assign shift_pulse = tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
      pin_q  <= 1'b0;
    end else begin
      trig_q <= trig_act;
      pin_q  <= pin_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en       <= 1'b0;
      tmr_out  <= 1'b0;
      lo_cnt   <= '0;
      hi_cnt   <= '0;
      phase    <= PH_RUN;
      sub      <= 1'b0;
      dis_pend <= 1'b0;
    end else if (!mode_on) begin
      en      <= 1'b0;
      tmr_out <= 1'b0;
      phase   <= PH_RUN;
      sub     <= 1'b0;
    end else if (ena_evt) begin
      en       <= 1'b1;
      tmr_out  <= 1'b1;
      lo_cnt   <= lo_ld;
      hi_cnt   <= hi_ld;
      phase    <= cfg_start_en ? PH_START : PH_RUN;
      sub      <= 1'b0;
      dis_pend <= 1'b0;
    end else if (en) begin
      if (rst_evt) begin
        lo_cnt <= lo_ld;
        hi_cnt <= hi_ld;
        phase  <= PH_RUN;
        sub    <= 1'b0;
        if (!cfg_out_sel) tmr_out <= 1'b1;
      end else if (tick) begin
        lo_cnt <= lo_ld;
        if (go_off) begin
          en      <= 1'b0;
          tmr_out <= 1'b0;
        end else begin
          tmr_out <= ~tmr_out;
        end
        case (phase)
          PH_RUN: begin
            if (hi_cnt == '0) begin
              hi_cnt <= hi_ld;
              if (stop_now) begin
                phase    <= PH_STOP;
                dis_pend <= dis_cond;
              end
            end else begin
              hi_cnt <= hi_cnt - ONE;
            end
          end
          default: begin
            if (sub) begin
              sub   <= 1'b0;
              phase <= PH_RUN;
            end else begin
              sub <= 1'b1;
            end
          end
        endcase
      end else begin
        lo_cnt <= lo_cnt - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tmr_stat <= 1'b0;
    else if (cmp_evt)  tmr_stat <= 1'b1;
    else if (stat_clr) tmr_stat <= 1'b0;
  end

  assert_pulse_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_pulse && cfg_cmp[BW-1:0] != '0) |=> !shift_pulse);

  assert_mode_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode != MODE_BAUD) |=> (!shift_pulse && !tmr_out));

  assert_out_on_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> tmr_out);

  assert_stat_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_evt |=> tmr_stat);

  assert_idle_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !tmr_out);
endmodule

// File: tb/sim_baud_timer.sv
module sim_baud_timer;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cfg_mode = 2'd1, cfg_dis_sel = 2'd1, cfg_stop_sel = 2'd0;
  logic [15:0] cfg_cmp = 16'h0303;
  logic cfg_ena_sel = 1'b1, cfg_rst_sel = 1'b0, cfg_out_sel = 1'b0, cfg_start_en = 1'b0;
  logic cfg_trig_src = 1'b0, cfg_trig_pol = 1'b0;
  logic shf_flag = 1'b0, trig_ext = 1'b0, pin_in = 1'b0, stat_clr = 1'b0;
  logic shift_pulse, tmr_out, tmr_stat;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  baud_timer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_cmp(cfg_cmp),
    .cfg_ena_sel(cfg_ena_sel), .cfg_dis_sel(cfg_dis_sel), .cfg_rst_sel(cfg_rst_sel),
    .cfg_out_sel(cfg_out_sel), .cfg_start_en(cfg_start_en), .cfg_stop_sel(cfg_stop_sel),
    .cfg_trig_src(cfg_trig_src), .cfg_trig_pol(cfg_trig_pol), .shf_flag(shf_flag),
    .trig_ext(trig_ext), .pin_in(pin_in), .stat_clr(stat_clr),
    .shift_pulse(shift_pulse), .tmr_out(tmr_out), .tmr_stat(tmr_stat)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_edges(int h, bit st, logic [1:0] sp);
    return h + 1 + (st ? 2 : 0) + ((sp == 2'd1 || sp == 2'd2) ? 2 : 0);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic clear_stat();
    @(negedge clk); stat_clr = 1'b1;
    @(negedge clk); stat_clr = 1'b0;
    chk("R11 clear", int'(tmr_stat), 0);
  endtask

  // one pin-started word with disable on compare
  task automatic pin_word(input int l, input int h, input bit st, input logic [1:0] sp);
    int n, cnt, first, last;
    n = exp_edges(h, st, sp);
    cnt = 0; first = 0; last = 0;
    @(negedge clk);
    cfg_cmp = {8'(h), 8'(l)}; cfg_start_en = st; cfg_stop_sel = sp;
    cfg_ena_sel = 1'b1; cfg_dis_sel = 2'd1; pin_in = 1'b0;
    @(negedge clk); pin_in = 1'b1;
    for (int c = 1; c <= n * (l + 1) + 2 * (l + 1) + 4; c++) begin
      @(negedge clk);
      if (c == 1) chk("R7 out high after pin edge", int'(tmr_out), 1);
      if (shift_pulse) begin
        cnt++;
        if (first == 0) first = c;
        last = c;
      end
    end
    chk("R4/R5/R6 edge count", cnt, n);
    chk("R3 first strobe", first, l + 1);
    chk("R3 last strobe", last, n * (l + 1));
    chk("R12 out low after stop", int'(tmr_out), 0);
    chk("R11 stat set", int'(tmr_stat), 1);
    pin_in = 1'b0;
    clear_stat();
  endtask

  task automatic reload_test(input bit osel);
    int cnt;
    cnt = 0;
    @(negedge clk);
    cfg_cmp = 16'h0703; cfg_start_en = 1'b0; cfg_stop_sel = 2'd0; cfg_ena_sel = 1'b1;
    cfg_dis_sel = 2'd1; cfg_rst_sel = 1'b1; cfg_out_sel = osel;
    cfg_trig_src = 1'b1; cfg_trig_pol = 1'b0; trig_ext = 1'b0; pin_in = 1'b0;
    @(negedge clk); pin_in = 1'b1;
    while (cnt < 3) begin
      @(negedge clk);
      if (shift_pulse) cnt++;
    end
    @(negedge clk); trig_ext = 1'b1;
    @(negedge clk);
    chk("R10 output after reload", int'(tmr_out), osel ? 0 : 1);
    for (int c = 0; c < 80; c++) begin
      if (shift_pulse) cnt++;
      @(negedge clk);
    end
    chk("R10 edges after reload", cnt, 3 + 8);
    trig_ext = 1'b0; pin_in = 1'b0; cfg_rst_sel = 1'b0;
    clear_stat();
  endtask

  initial begin
    #(CLK_NS * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int unsigned seed;
    int cnt;
    seed = $urandom(32'd4711);
    #(CLK_NS * 3);
    @(negedge clk);
    chk("R1 pulse", int'(shift_pulse), 0);
    chk("R1 out", int'(tmr_out), 0);
    chk("R1 stat", int'(tmr_stat), 0);
    rst_n = 1'b1;

    // R2: mode off ignores pin edge
    @(negedge clk); cfg_mode = 2'd0; pin_in = 1'b0;
    @(negedge clk); pin_in = 1'b1;
    cnt = 0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      if (shift_pulse || tmr_out) cnt++;
    end
    chk("R2 off stays quiet", cnt, 0);
    pin_in = 1'b0; cfg_mode = 2'd1;

    // directed corners
    pin_word(0, 0, 1'b0, 2'd0);
    pin_word(0, 15, 1'b0, 2'd0);
    pin_word(3, 15, 1'b1, 2'd1);
    pin_word(2, 4, 1'b0, 2'd2);
    pin_word(5, 2, 1'b1, 2'd2);

    // random words
    for (int i = 0; i < 16; i++) begin
      pin_word(int'($urandom_range(12, 0)), int'($urandom_range(15, 0)),
               1'($urandom_range(1, 0)), 2'($urandom_range(2, 0)));
    end

    // R2: mode drop mid-run
    @(negedge clk); cfg_cmp = 16'h0F04; cfg_stop_sel = 2'd0; cfg_start_en = 1'b0;
    @(negedge clk); pin_in = 1'b1;
    repeat (3) @(negedge clk);
    cfg_mode = 2'd0;
    @(negedge clk);
    chk("R2 mode drop", int'(shift_pulse | tmr_out), 0);
    cfg_mode = 2'd1; pin_in = 1'b0;
    repeat (3) @(negedge clk);
    clear_stat();

    // R8/R9: trigger level run, internal flag, active high
    cfg_cmp = 16'h0302; cfg_ena_sel = 1'b0; cfg_dis_sel = 2'd2;
    cfg_trig_src = 1'b0; cfg_trig_pol = 1'b0;
    shf_flag = 1'b1;
    cnt = 0;
    for (int c = 0; c < 100; c++) begin
      @(negedge clk);
      if (shift_pulse) cnt++;
    end
    chk("R9 runs past one word", int'(cnt > 4), 1);
    shf_flag = 1'b0;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      if (shift_pulse) cnt++;
    end
    chk("R9 stops on word boundary", cnt % 4, 0);
    chk("R12 out low after trigger stop", int'(tmr_out), 0);

    // R8: external trigger, active low
    cfg_trig_src = 1'b1; cfg_trig_pol = 1'b1; cfg_dis_sel = 2'd1; trig_ext = 1'b1;
    cnt = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (shift_pulse) cnt++;
    end
    chk("R8 inactive low-polarity trigger", cnt, 0);
    trig_ext = 1'b0;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      if (shift_pulse) cnt++;
    end
    chk("R8 active low-polarity trigger", int'(cnt > 0), 1);
    trig_ext = 1'b1;
    repeat (40) @(negedge clk);
    chk("R8 stopped after release", int'(tmr_out), 0);
    cfg_trig_pol = 1'b0; trig_ext = 1'b0;
    clear_stat();

    reload_test(1'b0);
    reload_test(1'b1);

    finish_run();
  end
endmodule